// File: doc/BRIEF.md
# Receive Packet Framer with Header Filtering

This block sits behind a demodulator and clock-recovery stage and turns a recovered bit stream into accepted packet payload. Each received bit arrives as a one-cycle strobe with its value. In the search phase the framer measures the run of alternating bits. Once that run reaches the programmed length, it hunts for a sync word of one to four bytes, then collects up to four header bytes.

The header is compared against programmable check bytes. A per-bit mask selects which bits are compared, and a per-byte broadcast enable also accepts an all-ones byte. After a good header, a length byte is taken from the stream, or a fixed length is used instead. The payload bytes are then presented one at a time toward an external FIFO. Status flags report preamble found, preamble broken, sync found, header rejected and packet complete.

Bits travel most significant bit first. When a sync search times out or a header is rejected, the framer returns to preamble search. Dropping the receive enable clears all framing state.

Top module: `rx_pkt_framer`

## Requirements
- R1: `pre_vld_o` rises on the bit strobe that completes a run of `4*pre_nib_i` consecutive alternating bits, where a value of 0 counts as 1 nibble. A shorter run leaves it low.
- R2: `pre_inv_o` gives a one-cycle pulse when, during preamble search, a bit equal to the previous bit arrives. This never happens within the first 16 bit strobes after `rx_en_i` rises.
- R3: The sync word is `sync_len_i+1` bytes, matched from `sync_word_i[31:24]` downward. On the strobe that completes it, `sync_det_o` rises and `pre_vld_o` falls.
- R4: If no sync match occurs within `sync_tmo_i` bit strobes after preamble detection, `pre_vld_o` falls and preamble search restarts.
- R5: `hdr_len_i` header bytes follow the sync word, with values above 4 treated as 4. The first received byte is compared to `hdr_chk_i[31:24]`, the next to `[23:16]`, and so on. Only bits whose `hdr_mask_i` bit is 1 are compared.
- R6: `bcast_en_i[3]` covers the byte at `[31:24]`, down to `bcast_en_i[0]` for `[7:0]`. When a byte's bit is set, a received value of FFh also passes that byte.
- R7: On a header mismatch, `hdr_err_o` pulses for one cycle and `sync_det_o` falls. No payload byte is output.
- R8: With `fix_len_en_i` = 0, the byte after the header gives the payload count, which is shown on `pkt_len_o`.
- R9: With `fix_len_en_i` = 1, no length byte is read. The payload count is `fix_len_i`, which is shown on `pkt_len_o`.
- R10: Each payload byte appears on `data_o` with a one-cycle `data_vld_o` pulse, in order, with its first received bit as bit 7. With the last byte, or at once for a count of 0, `pkt_vld_o` pulses and `sync_det_o` falls.
- R11: While `rx_en_i` is low, all flags and pulses are low, and framing restarts from preamble search when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable; low clears framing |
| bit_vld_i | input | 1 | Strobe for one received bit |
| bit_i | input | 1 | Received bit value |
| pre_nib_i | input | 9 | Preamble length in nibbles |
| sync_len_i | input | 2 | Sync word length minus one, in bytes |
| sync_word_i | input | 32 | Sync pattern, first byte at [31:24] |
| sync_tmo_i | input | 16 | Sync search limit in bit strobes |
| hdr_len_i | input | 3 | Header byte count |
| hdr_chk_i | input | 32 | Expected header bytes |
| hdr_mask_i | input | 32 | Per-bit header compare enable |
| bcast_en_i | input | 4 | Per-byte FFh acceptance |
| fix_len_en_i | input | 1 | Use fixed payload length |
| fix_len_i | input | 8 | Fixed payload length |
| data_o | output | 8 | Payload byte |
| data_vld_o | output | 1 | Payload byte strobe |
| pkt_len_o | output | 8 | Payload count of current packet |
| pre_vld_o | output | 1 | Preamble found, sync search active |
| pre_inv_o | output | 1 | Preamble broken pulse |
| sync_det_o | output | 1 | Sync found, packet in progress |
| hdr_err_o | output | 1 | Header rejected pulse |
| pkt_vld_o | output | 1 | Packet complete pulse |

## Verification
The assertions assume that configuration inputs stay steady from the start of a preamble until the packet ends or is dropped. They also assume that bit strobes come only while the receiver is enabled. The stimulus reprograms the framer only while `rx_en_i` is low between packets. Each sync word starts with 2Dh, whose leading `00` cannot appear inside an alternating preamble, so no match can form early across the preamble tail. Random header values are drawn either inside the masked tolerance or freely, so that both acceptance and rejection paths are exercised.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    ST_SRCH,
    ST_SYNC,
    ST_HDR,
    ST_LEN,
    ST_PAY
  } rxf_st_e;
endpackage

// File: rtl/rxf_pre_det.sv
module rxf_pre_det #(
  parameter int NIB_W  = 9,
  parameter int SETTLE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             act_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic [NIB_W-1:0] pre_nib_i,
  output logic             hit_o,
  output logic             inv_o
);
  localparam int RUN_W = NIB_W + 2;
  localparam int SET_W = $clog2(SETTLE + 1);

  logic [RUN_W-1:0] run_q, run_nx, thr;
  logic [SET_W-1:0] settle_q;
  logic             prev_q;
  logic             settled;

  assign settled = (settle_q == SET_W'(SETTLE));
  assign thr     = {((pre_nib_i == '0) ? NIB_W'(1) : pre_nib_i), 2'b00};

  always_comb begin
    if (run_q != '0 && bit_i != prev_q)
      run_nx = (run_q == '1) ? run_q : run_q + 1'b1;
    else
      run_nx = RUN_W'(1);
  end

  assign hit_o = act_i && bit_vld_i && (run_nx >= thr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= '0;
      settle_q <= '0;
      prev_q   <= 1'b0;
      inv_o    <= 1'b0;
    end else if (!en_i) begin
      run_q    <= '0;
      settle_q <= '0;
      prev_q   <= 1'b0;
      inv_o    <= 1'b0;
    end else begin
      inv_o <= 1'b0;
      if (!act_i) run_q <= '0;
      if (bit_vld_i) begin
        prev_q <= bit_i;
        if (!settled) settle_q <= settle_q + 1'b1;
        if (act_i) begin
          run_q <= run_nx;
          inv_o <= settled && (run_q != '0) && (bit_i == prev_q);
        end
      end
    end
  end

  // R2: a break pulse only follows a received bit
  a_r2_inv_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> $past(bit_vld_i) && $past(act_i));
endmodule

// File: rtl/rxf_sync_match.sv
module rxf_sync_match (
  input  logic [31:0] win_i,
  input  logic [31:0] word_i,
  input  logic [1:0]  len_i,
  output logic        match_o
);
  logic [5:0]  sa;
  logic [31:0] msk, pat;

  assign sa      = {1'b0, ~len_i, 3'b000};
  assign msk     = 32'hFFFF_FFFF >> sa;
  assign pat     = word_i >> sa;
  assign match_o = ((win_i ^ pat) & msk) == 32'h0;
endmodule

// File: rtl/rxf_hdr_chk.sv
module rxf_hdr_chk #(
  parameter int NB = 4
) (
  input  logic [8*NB-1:0] raw_i,
  input  logic [2:0]      cnt_i,
  input  logic [8*NB-1:0] chk_i,
  input  logic [8*NB-1:0] mask_i,
  input  logic [NB-1:0]   bcast_i,
  output logic            pass_o
);
  localparam int W = 8 * NB;

  logic [W-1:0]  al;
  logic [NB-1:0] ok;
  logic [5:0]    sa;

  assign sa = {3'(3'(NB) - cnt_i), 3'b000};
  assign al = raw_i << sa;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] rb, cb, mb;
    logic       used;
    assign rb    = al[8*i +: 8];
    assign cb    = chk_i[8*i +: 8];
    assign mb    = mask_i[8*i +: 8];
    assign used  = (int'(cnt_i) + i) >= NB;
    assign ok[i] = !used || (((rb ^ cb) & mb) == 8'h00) ||
                   (bcast_i[i] && rb == 8'hFF);
  end

  assign pass_o = &ok;
endmodule

// File: rtl/rx_pkt_framer.sv
module rx_pkt_framer
  import rxf_pkg::*;
#(
  parameter int NIB_W  = 9,
  parameter int TMO_W  = 16,
  parameter int SETTLE = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic [NIB_W-1:0] pre_nib_i,
  input  logic [1:0]       sync_len_i,
  input  logic [31:0]      sync_word_i,
  input  logic [TMO_W-1:0] sync_tmo_i,
  input  logic [2:0]       hdr_len_i,
  input  logic [31:0]      hdr_chk_i,
  input  logic [31:0]      hdr_mask_i,
  input  logic [3:0]       bcast_en_i,
  input  logic             fix_len_en_i,
  input  logic [7:0]       fix_len_i,
  output logic [7:0]       data_o,
  output logic             data_vld_o,
  output logic [7:0]       pkt_len_o,
  output logic             pre_vld_o,
  output logic             pre_inv_o,
  output logic             sync_det_o,
  output logic             hdr_err_o,
  output logic             pkt_vld_o
);
  localparam int HDR_MAX = 4;

  rxf_st_e          st_q;
  logic [31:0]      sh_q, sh_nx, hreg_q, hdr_nx;
  logic [2:0]       bitc_q, hcnt_q, hcnt_nx, hk;
  logic [7:0]       len_q, pcnt_q, data_q, byte_nx;
  logic [TMO_W-1:0] tmo_q;
  logic             dvld_q, pvld_q, herr_q;
  logic             pre_hit, sync_hit, hdr_pass, byte_done, tmo_end;

  assign sh_nx     = {sh_q[30:0], bit_i};
  assign byte_nx   = sh_nx[7:0];
  assign byte_done = bit_vld_i && (bitc_q == 3'd7);
  assign hk        = (hdr_len_i > 3'(HDR_MAX)) ? 3'(HDR_MAX) : hdr_len_i;
  assign hdr_nx    = {hreg_q[23:0], byte_nx};
  assign hcnt_nx   = hcnt_q + 1'b1;
  assign tmo_end   = ({1'b0, tmo_q} + 1'b1) >= {1'b0, sync_tmo_i};

  rxf_pre_det #(.NIB_W(NIB_W), .SETTLE(SETTLE)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en_i),
    .act_i     (st_q == ST_SRCH),
    .bit_vld_i (bit_vld_i),
    .bit_i     (bit_i),
    .pre_nib_i (pre_nib_i),
    .hit_o     (pre_hit),
    .inv_o     (pre_inv_o)
  );

  rxf_sync_match u_sync (
    .win_i   (sh_nx),
    .word_i  (sync_word_i),
    .len_i   (sync_len_i),
    .match_o (sync_hit)
  );

  rxf_hdr_chk #(.NB(HDR_MAX)) u_hdr (
    .raw_i   (hdr_nx),
    .cnt_i   (hcnt_nx),
    .chk_i   (hdr_chk_i),
    .mask_i  (hdr_mask_i),
    .bcast_i (bcast_en_i),
    .pass_o  (hdr_pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_SRCH; sh_q <= '0; hreg_q <= '0; bitc_q <= '0; hcnt_q <= '0;
      len_q <= '0; pcnt_q <= '0; data_q <= '0; tmo_q <= '0;
      dvld_q <= 1'b0; pvld_q <= 1'b0; herr_q <= 1'b0;
    end else if (!rx_en_i) begin
      st_q <= ST_SRCH; sh_q <= '0; hreg_q <= '0; bitc_q <= '0; hcnt_q <= '0;
      len_q <= '0; pcnt_q <= '0; data_q <= '0; tmo_q <= '0;
      dvld_q <= 1'b0; pvld_q <= 1'b0; herr_q <= 1'b0;
    end else begin
      dvld_q <= 1'b0;
      pvld_q <= 1'b0;
      herr_q <= 1'b0;
      if (bit_vld_i) begin
        sh_q   <= sh_nx;
        bitc_q <= bitc_q + 1'b1;
      end
      unique case (st_q)
        ST_SRCH: if (pre_hit) begin
          st_q  <= ST_SYNC;
          tmo_q <= '0;
        end
        ST_SYNC: if (bit_vld_i) begin
          if (sync_hit) begin
            bitc_q <= '0;
            hcnt_q <= '0;
            pcnt_q <= '0;
            if (hk != 3'd0) st_q <= ST_HDR;
            else if (!fix_len_en_i) st_q <= ST_LEN;
            else begin
              len_q <= fix_len_i;
              if (fix_len_i == 8'd0) begin
                pvld_q <= 1'b1;
                st_q   <= ST_SRCH;
              end else st_q <= ST_PAY;
            end
          end else if (tmo_end) st_q <= ST_SRCH;
          else tmo_q <= tmo_q + 1'b1;
        end
        ST_HDR: if (byte_done) begin
          hreg_q <= hdr_nx;
          hcnt_q <= hcnt_nx;
          if (hcnt_nx == hk) begin
            if (!hdr_pass) begin
              herr_q <= 1'b1;
              st_q   <= ST_SRCH;
            end else if (!fix_len_en_i) st_q <= ST_LEN;
            else begin
              len_q <= fix_len_i;
              if (fix_len_i == 8'd0) begin
                pvld_q <= 1'b1;
                st_q   <= ST_SRCH;
              end else st_q <= ST_PAY;
            end
          end
        end
        ST_LEN: if (byte_done) begin
          len_q <= byte_nx;
          if (byte_nx == 8'd0) begin
            pvld_q <= 1'b1;
            st_q   <= ST_SRCH;
          end else st_q <= ST_PAY;
        end
        ST_PAY: if (byte_done) begin
          data_q <= byte_nx;
          dvld_q <= 1'b1;
          pcnt_q <= pcnt_q + 1'b1;
          if ((pcnt_q + 1'b1) == len_q) begin
            pvld_q <= 1'b1;
            st_q   <= ST_SRCH;
          end
        end
        default: st_q <= ST_SRCH;
      endcase
    end
  end

  assign data_o     = data_q;
  assign data_vld_o = dvld_q;
  assign pkt_len_o  = len_q;
  assign pkt_vld_o  = pvld_q;
  assign hdr_err_o  = herr_q;
  assign pre_vld_o  = (st_q == ST_SYNC);
  assign sync_det_o = (st_q == ST_HDR) || (st_q == ST_LEN) || (st_q == ST_PAY);

  // R2: break pulses only come from the search phase
  a_r2_inv_in_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_inv_o |-> !$past(pre_vld_o) && !$past(sync_det_o));
  // R3: sync is only reached through a detected preamble
  a_r3_sync_after_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_det_o) |-> $past(pre_vld_o));
  // R7: rejection ends the packet with no payload
  a_r7_herr_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |-> !sync_det_o && !data_vld_o && $past(sync_det_o));
  // R10: payload only inside a synced packet
  a_r10_data_in_pkt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> $past(sync_det_o) && $past(bit_vld_i));
  // R10: completion closes the packet
  a_r10_pkt_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_vld_o |-> !sync_det_o && !hdr_err_o && ($past(sync_det_o) || $past(pre_vld_o)));
  // R11: disable clears the flags
  a_r11_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !pre_vld_o && !sync_det_o && !pkt_vld_o && !pre_inv_o);
endmodule

// File: tb/rx_pkt_framer_test.sv
module rx_pkt_framer_test;
  localparam int CLK_P = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, rx_en_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0;
  logic [8:0]  pre_nib_i = 9'd8;
  logic [1:0]  sync_len_i = 2'd1;
  logic [31:0] sync_word_i = 32'h2DD4_0000;
  logic [15:0] sync_tmo_i = 16'd200;
  logic [2:0]  hdr_len_i = 3'd0;
  logic [31:0] hdr_chk_i = '0, hdr_mask_i = '1;
  logic [3:0]  bcast_en_i = '0;
  logic        fix_len_en_i = 1'b0;
  logic [7:0]  fix_len_i = '0;
  logic [7:0]  data_o, pkt_len_o;
  logic        data_vld_o, pre_vld_o, pre_inv_o, sync_det_o, hdr_err_o, pkt_vld_o;

  int n_run = 0, n_fail = 0;
  int got_n = 0, pkt_n = 0, herr_n = 0, inv_n = 0;
  logic [7:0] got [64];
  logic [7:0] pay [16];
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  rx_pkt_framer uut (.*);

  always @(negedge clk_i) begin
    if (data_vld_o && got_n < 64) begin got[got_n] = data_o; got_n++; end
    if (pkt_vld_o) pkt_n++;
    if (hdr_err_o) herr_n++;
    if (pre_inv_o) inv_n++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    bit_vld_i = 1'b1; bit_i = b;
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    if ($urandom_range(0, 2) == 0) @(negedge clk_i);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_pre(input int nb);
    for (int i = 0; i < nb; i++) send_bit(~i[0]);
  endtask

  task automatic restart();
    @(negedge clk_i); rx_en_i = 1'b0;
    @(negedge clk_i);
    got_n = 0; pkt_n = 0; herr_n = 0; inv_n = 0;
    rx_en_i = 1'b1;
  endtask

  function automatic bit hdr_ok(input logic [31:0] sent, input int k);
    bit r = 1'b1;
    for (int i = 0; i < k; i++) begin
      logic [7:0] rb, cb, mb;
      rb = sent[31-8*i -: 8]; cb = hdr_chk_i[31-8*i -: 8]; mb = hdr_mask_i[31-8*i -: 8];
      if (!(((rb & mb) == (cb & mb)) || (bcast_en_i[3-i] && rb == 8'hFF))) r = 1'b0;
    end
    return r;
  endfunction

  task automatic run_pkt(input int sl, input int pn, input int hl, input logic [31:0] sent,
                         input int len, input bit fx);
    int k;
    bit ok;
    k = (hl > 4) ? 4 : hl;
    for (int p = 0; p < 16; p++) pay[p] = 8'($urandom);
    restart();
    sync_len_i = 2'(sl); pre_nib_i = 9'(pn); hdr_len_i = 3'(hl);
    fix_len_en_i = fx; fix_len_i = 8'(len); sync_tmo_i = 16'd200;
    send_pre((pn == 0) ? 4 : pn * 4);
    chk(pre_vld_o == 1'b1, "R1 pre_vld after full preamble", 32'(pre_vld_o), 1);
    for (int b = 0; b <= sl; b++) send_byte(sync_word_i[31-8*b -: 8]);
    if (!(k == 0 && fx && len == 0))
      chk(sync_det_o && !pre_vld_o, "R3 sync_det up, pre_vld down", {sync_det_o, pre_vld_o}, 2'b10);
    for (int b = 0; b < k; b++) send_byte(sent[31-8*b -: 8]);
    ok = hdr_ok(sent, k);
    if (ok) begin
      if (!fx) send_byte(8'(len));
      for (int p = 0; p < len; p++) send_byte(pay[p]);
    end
    repeat (3) @(negedge clk_i);
    if (ok) begin
      chk(herr_n == 0 && pkt_n == 1, "R5/R6 header accepted, R10 pkt_vld", {herr_n[15:0], pkt_n[15:0]}, 1);
      chk(got_n == len, "R10 payload count", got_n, len);
      for (int p = 0; p < len && p < got_n; p++)
        chk(got[p] == pay[p], "R10 payload byte", got[p], pay[p]);
      chk(pkt_len_o == 8'(len), fx ? "R9 fixed length" : "R8 length byte", pkt_len_o, len);
      chk(!sync_det_o, "R10 sync_det falls", sync_det_o, 0);
    end else begin
      chk(herr_n == 1 && pkt_n == 0, "R7 header rejected", {herr_n[15:0], pkt_n[15:0]}, 32'h10000);
      chk(got_n == 0 && !sync_det_o, "R7 no payload", got_n, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({data_vld_o, pre_vld_o, pre_inv_o, sync_det_o, hdr_err_o, pkt_vld_o} == 6'b0,
        "R11 reset state", {data_vld_o, pre_vld_o, pre_inv_o, sync_det_o, hdr_err_o, pkt_vld_o}, 0);

    // R1 short preamble, R4 timeout
    restart();
    pre_nib_i = 9'd3; sync_tmo_i = 16'd20;
    send_pre(11);
    chk(!pre_vld_o, "R1 short run", pre_vld_o, 0);
    send_bit(1'b0);
    chk(pre_vld_o, "R1 exact run", pre_vld_o, 1);
    for (int i = 0; i < 19; i++) send_bit(1'b1);
    chk(pre_vld_o, "R4 before limit", pre_vld_o, 1);
    send_bit(1'b1);
    chk(!pre_vld_o && !sync_det_o, "R4 timeout", {pre_vld_o, sync_det_o}, 0);

    // R2 settling window
    restart();
    pre_nib_i = 9'd8;
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    chk(inv_n == 0, "R2 settle hold-off", inv_n, 0);
    send_bit(1'b1);
    @(negedge clk_i);
    chk(inv_n == 1, "R2 break after settle", inv_n, 1);

    // directed packets
    sync_word_i = 32'h2DD4_5A3C; hdr_chk_i = 32'hA1B2_C3D4; hdr_mask_i = '1; bcast_en_i = '0;
    run_pkt(1, 8, 2, 32'hA1B2_0000, 3, 1'b0);
    run_pkt(1, 8, 2, 32'hA1B3_0000, 3, 1'b0);              // R7 mismatch
    hdr_mask_i = 32'hFFFE_FFFF;
    run_pkt(1, 8, 2, 32'hA1B3_0000, 2, 1'b0);              // R5 masked bit ignored
    hdr_mask_i = '1; bcast_en_i = 4'b0100;
    run_pkt(2, 4, 2, 32'hA1FF_0000, 2, 1'b0);              // R6 broadcast accepted
    bcast_en_i = 4'b1000;
    run_pkt(2, 4, 2, 32'hA1FF_0000, 2, 1'b0);              // R6 broadcast off for that byte
    bcast_en_i = '0;
    run_pkt(3, 2, 7, 32'hA1B2_C3D4, 4, 1'b0);              // R5 length above 4
    run_pkt(0, 0, 4, 32'hA1B2_C3D5, 1, 1'b0);              // R5 last byte compared
    run_pkt(1, 8, 0, 32'h0, 5, 1'b1);                      // R9 fixed
    run_pkt(1, 8, 1, 32'hA100_0000, 0, 1'b0);              // R10 zero length
    run_pkt(1, 8, 0, 32'h0, 0, 1'b1);                      // R9/R10 fixed zero

    // R11 disable mid-packet
    restart();
    hdr_len_i = 3'd0; fix_len_en_i = 1'b0; sync_len_i = 2'd1; pre_nib_i = 9'd4;
    send_pre(16); send_byte(8'h2D); send_byte(8'hD4); send_byte(8'd4); send_byte(8'h11);
    @(negedge clk_i); rx_en_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    chk(!sync_det_o && !pre_vld_o && pkt_n == 0, "R11 disable clears", {sync_det_o, pre_vld_o}, 0);

    // random mix
    for (int t = 0; t < 30; t++) begin
      logic [31:0] sent, rm;
      sync_word_i = {16'h2DD4, 16'($urandom)};
      hdr_chk_i = $urandom; rm = $urandom;
      hdr_mask_i = $urandom | 32'hF0F0_F0F0;
      bcast_en_i = 4'($urandom);
      case ($urandom_range(0, 3))
        0: sent = $urandom;
        1: sent = 32'hFFFF_FFFF;
        default: sent = hdr_chk_i ^ (rm & ~hdr_mask_i);
      endcase
      run_pkt($urandom_range(0, 3), $urandom_range(1, 16), $urandom_range(0, 5), sent,
              $urandom_range(0, 8), 1'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule